// File: doc/BRIEF.md
# SGRAM Mode and Special Register Command Decoder

This block sits on the memory side of a synchronous graphics DRAM interface. It samples the command pins on every rising clock edge: chip select, the row strobe, the column strobe, the write enable, the special-function strobe and the write-mode select. It also samples the ten address lines and the 32-bit data bus. It recognises three commands:

- a no-operation;
- a mode register load, which programs CAS latency, the burst field, the write mode and the test field;
- a special register load, which copies the data bus into a colour register or a mask register.

The decoded configuration is exported as plain registered outputs for the rest of the memory model. Two indications are also exported. One marks a reserved latency code. The other is a one-cycle pulse that marks an illegal special load.

The pins form a command bus and not a stream. A command is registered on every edge at which chip select is low. No valid/ready handshake exists, and the block never applies back-pressure. The issuer must present each command for exactly one cycle. A load takes one clock, so its effect is visible on the outputs in the cycle after the command edge.

Top module: `sgram_cfg_decoder`

## Requirements
- R1: Synchronous reset (rst high) sets `cas_lat`=2, `burst_cfg`=0, `single_write`=0, `test_mode`=0, `cl_reserved`=0, `color_reg`=0, `mask_reg`=0 and `smrs_illegal`=0.
- R2: A mode load has `cs_n`=0, `ras_n`=`cas_n`=`we_n`=0 and `dsf`=0. In the cycle after the command edge it updates three outputs: `burst_cfg` takes addr[3:0], `single_write` takes `bs` (1 = burst-read/single-write, 0 = burst-read/burst-write), and `cas_lat` takes the latency code on addr[6:4], where 001 means 1, 010 means 2 and 011 means 3.
- R3: A mode load with a reserved latency code (000 or 1xx on addr[6:4]) leaves `cas_lat` unchanged and sets `cl_reserved`. The next mode load with a valid code clears it.
- R4: A mode load sets `test_mode` when the test field addr[9:7] is nonzero and clears it when the field is 000.
- R5: A special load has `cs_n`=0, `ras_n`=`cas_n`=`we_n`=0 and `dsf`=1. With addr[6]=1 and addr[5]=0 it loads `color_reg` from `dq` for the next cycle. `mask_reg` and the mode outputs are unchanged.
- R6: A special load with addr[5]=1 and addr[6]=0 loads `mask_reg` from `dq` for the next cycle. `color_reg` is unchanged.
- R7: A special load with addr[6]=addr[5]=1 is illegal. Neither data register changes, and `smrs_illegal` is high for exactly the one cycle after the command edge.
- R8: A special load with addr[6]=addr[5]=0 changes no output.
- R9: A no-operation (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1) changes no output, whatever the other pins carry.
- R10: While `cs_n`=1 no command is registered and no output changes.
- R11: Any other pin combination with `cs_n`=0 (for example activate or write) changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function strobe; high selects the special load |
| bs | input | 1 | Write-mode select sampled by a mode load |
| addr | input | 10 | Address lines carrying the register fields |
| dq | input | 32 | Data bus carrying colour or mask values |
| cas_lat | output | 2 | Programmed CAS latency in clocks (1 to 3) |
| burst_cfg | output | 4 | Burst field from the last mode load |
| single_write | output | 1 | High when burst-read/single-write is selected |
| test_mode | output | 1 | High when the test field is nonzero |
| cl_reserved | output | 1 | High after a mode load with a reserved latency code |
| color_reg | output | 32 | Colour register |
| mask_reg | output | 32 | Mask register |
| smrs_illegal | output | 1 | One-cycle pulse after an illegal special load |

## Verification
The checker watches several properties on every cycle:
- a deselected cycle or a no-operation leaves the data registers and latency untouched;
- a colour load copies the previous cycle's data bus;
- the illegal pulse appears only after a special load with both selects set, and freezes both data registers;
- the latency output never leaves the range 1 to 3.

Other behaviour needs the directed scenarios:
- the full field decode of a mode load;
- the set and clear sequence of the reserved flag;
- how the test field combines its three address bits;
- the pulse width of the illegal indication;
- that other command encodings are ignored.

// File: rtl/sgram_cfg_pkg.sv
package sgram_cfg_pkg;

  // Address bit positions of the command fields (decoded by the memory side).
  localparam int BURST_LSB  = 0;
  localparam int BURST_W    = 4;
  localparam int CL_LSB     = 4;
  localparam int CL_W       = 3;
  localparam int TEST_LSB   = 7;
  localparam int TEST_W     = 3;
  localparam int SEL_MASK   = 5;
  localparam int SEL_COLOR  = 6;
  localparam int LAT_W      = 2;
  localparam logic [LAT_W-1:0] LAT_RESET = 2'd2;

  // Number of special data registers (index 0 = colour, 1 = mask).
  localparam int NUM_SREG   = 2;
  localparam int SREG_COLOR = 0;
  localparam int SREG_MASK  = 1;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_MRS   = 3'd2,
    CMD_SMRS  = 3'd3,
    CMD_OTHER = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [LAT_W-1:0]   lat;
    logic [BURST_W-1:0] burst;
    logic               single_wr;
    logic               test;
    logic               cl_rsvd;
  } mode_t;

  // Returns the latency in clocks, or zero for a reserved code.
  function automatic logic [LAT_W-1:0] cl_decode(input logic [CL_W-1:0] code);
    logic [LAT_W-1:0] r;
    unique case (code)
      3'b001:  r = 2'd1;
      3'b010:  r = 2'd2;
      3'b011:  r = 2'd3;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_cfg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic dsf,
  output cmd_e cmd,
  output logic mrs_en,
  output logic smrs_en
);

  logic all_low;
  logic all_high;

  always_comb begin
    all_low  = ~ras_n & ~cas_n & ~we_n;
    all_high =  ras_n &  cas_n &  we_n;
    if (cs_n)          cmd = CMD_DESEL;
    else if (all_high) cmd = CMD_NOP;
    else if (all_low)  cmd = dsf ? CMD_SMRS : CMD_MRS;
    else               cmd = CMD_OTHER;
  end

  assign mrs_en  = (cmd == CMD_MRS);
  assign smrs_en = (cmd == CMD_SMRS);

endmodule

// File: rtl/sgram_mode_reg.sv
module sgram_mode_reg
  import sgram_cfg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              bs,
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode_q
);

  logic [CL_W-1:0]    cl_code;
  logic [LAT_W-1:0]   cl_val;
  logic [TEST_W-1:0]  test_fld;
  logic [BURST_W-1:0] burst_fld;
  mode_t              mode_d;

  always_comb begin
    cl_code   = addr[CL_LSB +: CL_W];
    test_fld  = addr[TEST_LSB +: TEST_W];
    burst_fld = addr[BURST_LSB +: BURST_W];
    cl_val    = cl_decode(cl_code);
    mode_d    = mode_q;
    if (load) begin
      mode_d.burst     = burst_fld;
      mode_d.single_wr = bs;
      mode_d.test      = |test_fld;
      if (cl_val != '0) begin
        mode_d.lat     = cl_val;
        mode_d.cl_rsvd = 1'b0;
      end else begin
        mode_d.cl_rsvd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q.lat       <= LAT_RESET;
      mode_q.burst     <= '0;
      mode_q.single_wr <= 1'b0;
      mode_q.test      <= 1'b0;
      mode_q.cl_rsvd   <= 1'b0;
    end else begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/sgram_special_regs.sv
module sgram_special_regs
  import sgram_cfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DQ_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DQ_W-1:0]                dq,
  output logic [NUM_SREG-1:0][DQ_W-1:0]  sreg_q,
  output logic                           illegal_q
);

  logic [NUM_SREG-1:0] sel;
  logic                both;

  always_comb begin
    sel[SREG_COLOR] = addr[SEL_COLOR];
    sel[SREG_MASK]  = addr[SEL_MASK];
    both            = &sel;
  end

  for (genvar i = 0; i < NUM_SREG; i++) begin : g_sreg
    always_ff @(posedge clk) begin
      if (rst)
        sreg_q[i] <= '0;
      else if (load && sel[i] && !both)
        sreg_q[i] <= dq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= load && both;
  end

endmodule

// File: rtl/sgram_cfg_decoder.sv
module sgram_cfg_decoder
  import sgram_cfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DQ_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic              bs,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  output logic [1:0]        cas_lat,
  output logic [3:0]        burst_cfg,
  output logic              single_write,
  output logic              test_mode,
  output logic              cl_reserved,
  output logic [DQ_W-1:0]   color_reg,
  output logic [DQ_W-1:0]   mask_reg,
  output logic              smrs_illegal
);

  cmd_e                          cmd;
  logic                          mrs_en;
  logic                          smrs_en;
  mode_t                         mode_q;
  logic [NUM_SREG-1:0][DQ_W-1:0] sreg_q;

  sgram_cmd_decode u_dec (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .dsf     (dsf),
    .cmd     (cmd),
    .mrs_en  (mrs_en),
    .smrs_en (smrs_en)
  );

  sgram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .load   (mrs_en),
    .bs     (bs),
    .addr   (addr),
    .mode_q (mode_q)
  );

  sgram_special_regs #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_sregs (
    .clk       (clk),
    .rst       (rst),
    .load      (smrs_en),
    .addr      (addr),
    .dq        (dq),
    .sreg_q    (sreg_q),
    .illegal_q (smrs_illegal)
  );

  assign cas_lat      = mode_q.lat;
  assign burst_cfg    = mode_q.burst;
  assign single_write = mode_q.single_wr;
  assign test_mode    = mode_q.test;
  assign cl_reserved  = mode_q.cl_rsvd;
  assign color_reg    = sreg_q[SREG_COLOR];
  assign mask_reg     = sreg_q[SREG_MASK];

endmodule

// File: rtl/sgram_cfg_chk.sv
module sgram_cfg_chk #(
  parameter int ADDR_W = 10,
  parameter int DQ_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dsf,
  input logic [ADDR_W-1:0] addr,
  input logic [DQ_W-1:0]   dq,
  input logic [1:0]        cas_lat,
  input logic [DQ_W-1:0]   color_reg,
  input logic [DQ_W-1:0]   mask_reg,
  input logic              smrs_illegal
);

  logic primed;
  logic smrs_cmd;
  logic nop_cmd;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assign smrs_cmd = !cs_n && !ras_n && !cas_n && !we_n && dsf;
  assign nop_cmd  = !cs_n && ras_n && cas_n && we_n;

  // R2
  cas_lat_range_chk: assert property (@(posedge clk) disable iff (rst)
    cas_lat != 2'd0);

  // R5
  color_load_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(smrs_cmd && addr[6] && !addr[5]) |-> color_reg == $past(dq));

  // R7
  illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    primed && smrs_illegal |-> $past(smrs_cmd && addr[6] && addr[5]));

  // R7
  illegal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    primed && smrs_illegal |-> $stable(color_reg) && $stable(mask_reg));

  // R9
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(nop_cmd) |-> $stable(color_reg) && $stable(mask_reg) && $stable(cas_lat));

  // R10
  deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cs_n) |-> $stable(color_reg) && $stable(mask_reg)
                              && $stable(cas_lat) && !smrs_illegal);

endmodule

bind sgram_cfg_decoder sgram_cfg_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .dsf          (dsf),
  .addr         (addr),
  .dq           (dq),
  .cas_lat      (cas_lat),
  .color_reg    (color_reg),
  .mask_reg     (mask_reg),
  .smrs_illegal (smrs_illegal)
);

// File: tb/sgram_cfg_decoder_tb.sv
module sgram_cfg_decoder_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, ras_n, cas_n, we_n, dsf, bs;
  logic [9:0]  addr;
  logic [31:0] dq;
  logic [1:0]  cas_lat;
  logic [3:0]  burst_cfg;
  logic        single_write, test_mode, cl_reserved, smrs_illegal;
  logic [31:0] color_reg, mask_reg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sgram_cfg_decoder u_dut (
    .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .dsf (dsf), .bs (bs), .addr (addr), .dq (dq),
    .cas_lat (cas_lat), .burst_cfg (burst_cfg), .single_write (single_write),
    .test_mode (test_mode), .cl_reserved (cl_reserved), .color_reg (color_reg),
    .mask_reg (mask_reg), .smrs_illegal (smrs_illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    dsf = 1'b0; bs = 1'b0; addr = '0; dq = '0;
  endtask

  // Drives one command at a falling edge; returns at the next falling edge,
  // after the command has been registered.
  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic d, input logic b, input logic [9:0] a,
                       input logic [31:0] v);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; dsf = d; bs = b; addr = a; dq = v;
    @(negedge clk);
    idle_pins();
  endtask

  task automatic mrs(input logic [9:0] a, input logic b);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, b, a, 32'h0);
  endtask

  task automatic smrs(input logic [9:0] a, input logic [31:0] v);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, a, v);
  endtask

  task automatic t_reset();
    chk("R1 cas_lat", cas_lat, 2);
    chk("R1 burst_cfg", burst_cfg, 0);
    chk("R1 single_write", single_write, 0);
    chk("R1 test_mode", test_mode, 0);
    chk("R1 cl_reserved", cl_reserved, 0);
    chk("R1 color_reg", color_reg, 0);
    chk("R1 mask_reg", mask_reg, 0);
    chk("R1 smrs_illegal", smrs_illegal, 0);
  endtask

  task automatic t_mode_load();
    mrs(10'h015, 1'b1);
    chk("R2 lat code 001", cas_lat, 1);
    chk("R2 burst 5", burst_cfg, 4'h5);
    chk("R2 single write", single_write, 1);
    mrs(10'h03A, 1'b0);
    chk("R2 lat code 011", cas_lat, 3);
    chk("R2 burst A", burst_cfg, 4'hA);
    chk("R2 burst write", single_write, 0);
    mrs(10'h020, 1'b0);
    chk("R2 lat code 010", cas_lat, 2);
  endtask

  task automatic t_reserved();
    mrs(10'h000, 1'b0);
    chk("R3 code 000 keeps lat", cas_lat, 2);
    chk("R3 code 000 flag", cl_reserved, 1);
    mrs(10'h070, 1'b0);
    chk("R3 code 111 keeps lat", cas_lat, 2);
    chk("R3 code 111 flag", cl_reserved, 1);
    mrs(10'h030, 1'b0);
    chk("R3 valid code clears", cl_reserved, 0);
    chk("R3 valid code lat", cas_lat, 3);
  endtask

  task automatic t_test_field();
    mrs(10'h1B0, 1'b0);
    chk("R4 field 011", test_mode, 1);
    mrs(10'h220, 1'b0);
    chk("R4 field 100", test_mode, 1);
    mrs(10'h020, 1'b0);
    chk("R4 field 000", test_mode, 0);
  endtask

  task automatic t_color();
    smrs(10'h040, 32'hA5A5_1234);
    chk("R5 color loaded", color_reg, 32'hA5A5_1234);
    chk("R5 mask kept", mask_reg, 0);
    chk("R5 lat kept", cas_lat, 2);
  endtask

  task automatic t_mask();
    smrs(10'h020, 32'h0F0F_00FF);
    chk("R6 mask loaded", mask_reg, 32'h0F0F_00FF);
    chk("R6 color kept", color_reg, 32'hA5A5_1234);
  endtask

  task automatic t_both();
    smrs(10'h060, 32'hDEAD_BEEF);
    chk("R7 pulse high", smrs_illegal, 1);
    chk("R7 color kept", color_reg, 32'hA5A5_1234);
    chk("R7 mask kept", mask_reg, 32'h0F0F_00FF);
    @(negedge clk);
    chk("R7 pulse one cycle", smrs_illegal, 0);
  endtask

  task automatic t_neither();
    smrs(10'h000, 32'hFFFF_FFFF);
    chk("R8 color kept", color_reg, 32'hA5A5_1234);
    chk("R8 mask kept", mask_reg, 32'h0F0F_00FF);
    chk("R8 no reserved flag", cl_reserved, 0);
    chk("R8 no illegal", smrs_illegal, 0);
  endtask

  task automatic t_nop();
    issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'h060, 32'h1111_2222);
    chk("R9 color kept", color_reg, 32'hA5A5_1234);
    chk("R9 illegal low", smrs_illegal, 0);
    chk("R9 single_write kept", single_write, 0);
  endtask

  task automatic t_deselect();
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h040, 32'h3333_4444);
    chk("R10 color kept", color_reg, 32'hA5A5_1234);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h01F, 32'h0);
    chk("R10 lat kept", cas_lat, 2);
    chk("R10 burst kept", burst_cfg, 4'h0);
    chk("R10 single kept", single_write, 0);
  endtask

  task automatic t_other();
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'h01F, 32'h0);
    chk("R11 activate lat kept", cas_lat, 2);
    chk("R11 activate burst kept", burst_cfg, 4'h0);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'h020, 32'h5555_6666);
    chk("R11 write mask kept", mask_reg, 32'h0F0F_00FF);
  endtask

  initial begin
    idle_pins();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode_load();
    t_reserved();
    t_test_field();
    t_color();
    t_mask();
    t_both();
    t_neither();
    t_nop();
    t_deselect();
    t_other();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule